// File: doc/BRIEF.md
# Checksummed Configuration Image Transfer Sequencer

This block copies a configuration image, made of 16-bit words, between a local buffer RAM and an external nonvolatile word memory. The memory is driven through two registers: a command register, which takes an opcode combined with a word address and reports a completion flag, and a data register. Only the command/completion handshake is modelled here. The timing of the serial wires themselves belongs to the device side.

The image has three parts. A configuration region is covered by a 16-bit checksum. The checksum word follows that region directly. A control region comes after the checksum word and is moved with the image but is not summed. A load pass reads every word into the buffer and reports the sum of the configuration words, so the host can compare it with the stored checksum word. A store pass unlocks the memory, writes the configuration words, writes a freshly computed checksum in place of the buffer's copy, writes the control words, and then locks the memory again.

Completion is polled once per pulse of a 1 ms tick input. If a command does not complete within a fixed number of polls, the pass is abandoned and a timeout is flagged.

Top module: `cfgs_seq`

## Requirements
- R1: After reset, busy, done, timeout, every strobe (nv_cmd_wr, nv_data_wr, buf_we) and checksum are all 0.
- R2: Every command word is an opcode ORed with a zero-extended word address. The opcodes are load 16'h8000, store 16'h4000, unlock 16'h3000 and lock 16'h1000. Unlock and lock carry address 0.
- R3: A pass visits the memory addresses from the configuration start (0) up to and including the checksum address (21), then from the control start (22) to the last word (63), in ascending order. The buffer index is the 0-based position in this sequence. A load pass writes each returned word to the buffer at that index.
- R4: The checksum output is the 16-bit wrap-around sum of the words at addresses 0 to 20 only. The checksum word and the control words are left out. The output is valid when done pulses.
- R5: A store pass issues unlock first and lock last. It waits for completion after each of them, so a store pass issues 66 commands in total.
- R6: Each store command is preceded, in the cycle immediately before it, by a data-register load that carries the word to be written.
- R7: In a store pass, the checksum address receives the computed sum and not the buffer's copy. All other addresses receive the buffer word unchanged.
- R8: Completion is sampled only in cycles where tick_1ms is high. If 10 such samples pass without completion, the pass ends with timeout set and no further command is issued.
- R9: busy rises in the cycle after start is accepted and stays high until the done cycle. A start seen while busy has no effect.
- R10: done is a one-cycle pulse. timeout stays set after done until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse that paces completion polling |
| start | input | 1 | Begin a pass (ignored while busy) |
| wr_mode | input | 1 | 1 = store pass, 0 = load pass; sampled with start |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| timeout | output | 1 | Last pass was abandoned on a poll timeout |
| checksum | output | 16 | Sum of the configuration words of the last pass |
| buf_addr | output | 6 | Buffer word index |
| buf_rdata | input | 16 | Buffer read data, combinational from buf_addr |
| buf_we | output | 1 | Buffer write strobe (load pass) |
| buf_wdata | output | 16 | Buffer write data |
| nv_cmd_wr | output | 1 | Command register write strobe |
| nv_cmd | output | 16 | Command word |
| nv_data_wr | output | 1 | Data register write strobe |
| nv_wdata | output | 16 | Data register write value |
| nv_rdata | input | 16 | Data register read value, valid with nv_done |
| nv_done | input | 1 | Completion flag; the device clears it when a command is written |

## Verification
An accepted start shows as busy one cycle later. A load pass puts out its first command in that same cycle, and a store pass puts out its unlock command there. Each word finishes one cycle after the first tick edge at which the completion flag is seen, and done follows one cycle after the last completion or after the tenth unanswered tick. Inputs change on falling edges and outputs are sampled on falling edges, so the bench waits for the done pulse and then checks the memory model, the buffer model, the logged command stream and the outputs in the settled half-cycle after it. The timeout case counts the tick edges between the command strobe and done and expects exactly the poll limit.

// File: rtl/cfgs_pkg.sv
// Shared constants and types for the configuration image sequencer.
// Assumes a 16-bit command register with the opcode in the upper bits and
// the word address in the low bits.
package cfgs_pkg;
    localparam int WORD_W = 16;

    localparam logic [WORD_W-1:0] OP_LOAD   = 16'h8000;
    localparam logic [WORD_W-1:0] OP_STORE  = 16'h4000;
    localparam logic [WORD_W-1:0] OP_UNLOCK = 16'h3000;
    localparam logic [WORD_W-1:0] OP_LOCK   = 16'h1000;

    typedef enum logic [2:0] {
        S_IDLE, S_UNLOCK, S_LOAD_DATA, S_CMD, S_WAIT, S_LOCK, S_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_UNLOCK, PH_WORD, PH_LOCK
    } wait_phase_t;
endpackage

// File: rtl/cfgs_poll.sv
// Completion poll timer.
// Samples the device completion flag only on tick pulses while waiting.
// It reports success, or expiry after POLL_LIMIT unanswered samples.
// Assumes arm is pulsed in the cycle the command is written.
module cfgs_poll #(
    parameter int POLL_LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic waiting,
    input  logic tick,
    input  logic dev_done,
    output logic ok,
    output logic expire
);
    localparam int CW = $clog2(POLL_LIMIT + 1);
    localparam logic [CW-1:0] LAST_POLL = CW'(POLL_LIMIT - 1);

    logic [CW-1:0] polls;
    logic          sample;

    // a poll happens only on a tick while waiting
    assign sample = waiting && tick;
    assign ok     = sample && dev_done;
    assign expire = sample && !dev_done && (polls == LAST_POLL);

    // count unanswered polls since the last command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            polls <= '0;
        end else if (arm) begin
            polls <= '0;
        end else if (sample && !dev_done && polls != LAST_POLL) begin
            polls <= polls + 1'b1;
        end
    end

    // R8: the poll count never passes the limit
    a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        polls <= LAST_POLL);

    // R8: polling stays frozen between ticks
    a_r8_no_tick_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !arm) |=> $stable(polls));
endmodule

// File: rtl/cfgs_walk.sv
// Address walker.
// Steps through the configuration region and the checksum word, then jumps
// to the control region. It keeps the memory address and the buffer index.
// Assumes CFG_BEGIN < CFG_END < CTL_BEGIN < MAX_WORD. The walk never goes
// below CFG_BEGIN, so region membership needs only the upper bound.
module cfgs_walk #(
    parameter int CFG_BEGIN = 0,
    parameter int CFG_END   = 21,
    parameter int CTL_BEGIN = 22,
    parameter int MAX_WORD  = 64,
    localparam int AW       = $clog2(MAX_WORD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] idx,
    output logic          in_cfg,
    output logic          at_ck,
    output logic          at_last
);
    localparam logic [AW-1:0] A_BEGIN = AW'(CFG_BEGIN);
    localparam logic [AW-1:0] A_CK    = AW'(CFG_END);
    localparam logic [AW-1:0] A_CTL   = AW'(CTL_BEGIN);
    localparam logic [AW-1:0] A_LAST  = AW'(MAX_WORD - 1);

    // region decode of the current address
    assign in_cfg  = addr < A_CK;
    assign at_ck   = addr == A_CK;
    assign at_last = addr == A_LAST;

    // advance address and buffer index, skipping the gap after the checksum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            idx  <= '0;
        end else if (load) begin
            addr <= A_BEGIN;
            idx  <= '0;
        end else if (step) begin
            addr <= at_ck ? A_CTL : addr + 1'b1;
            idx  <= idx + 1'b1;
        end
    end

    // R3: the walk never leaves the image
    a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= A_LAST);

    // R3: after the checksum word the walk resumes at the control region
    a_r3_jump_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_ck && !load) |=> addr == A_CTL);
endmodule

// File: rtl/cfgs_sum.sv
// Checksum accumulator: a 16-bit wrap-around sum, cleared at pass start.
module cfgs_sum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         acc,
    input  logic [W-1:0] word,
    output logic [W-1:0] sum
);
    // accumulate summed words modulo 2^W
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clr) begin
            sum <= '0;
        end else if (acc) begin
            sum <= sum + word;
        end
    end

    // R4: the sum moves only when a word is accumulated
    a_r4_sum_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !acc) |=> $stable(sum));
endmodule

// File: rtl/cfgs_seq.sv
// Configuration image transfer sequencer (top).
// Runs a load pass (memory to buffer, sum reported) or a store pass
// (unlock, buffer to memory with the computed checksum inserted, lock).
// Assumes a buffer with combinational read, and a device that clears its
// completion flag when a command is written.
module cfgs_seq
    import cfgs_pkg::*;
#(
    parameter int CFG_BEGIN  = 0,
    parameter int CFG_END    = 21,
    parameter int CTL_BEGIN  = 22,
    parameter int MAX_WORD   = 64,
    parameter int POLL_LIMIT = 10,
    localparam int AW        = $clog2(MAX_WORD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1ms,
    input  logic              start,
    input  logic              wr_mode,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [WORD_W-1:0] checksum,
    output logic [AW-1:0]     buf_addr,
    input  logic [WORD_W-1:0] buf_rdata,
    output logic              buf_we,
    output logic [WORD_W-1:0] buf_wdata,
    output logic              nv_cmd_wr,
    output logic [WORD_W-1:0] nv_cmd,
    output logic              nv_data_wr,
    output logic [WORD_W-1:0] nv_wdata,
    input  logic [WORD_W-1:0] nv_rdata,
    input  logic              nv_done
);
    seq_state_t        state, state_n;
    wait_phase_t       phase, phase_n;
    logic              store_q;
    logic              tmo_q;
    logic              accept;
    logic              w_load, w_step, sum_acc;
    logic              poll_ok, poll_exp;
    logic [AW-1:0]     addr;
    logic              in_cfg, at_ck, at_last;
    logic [WORD_W-1:0] sum, sum_word;

    cfgs_walk #(
        .CFG_BEGIN (CFG_BEGIN),
        .CFG_END   (CFG_END),
        .CTL_BEGIN (CTL_BEGIN),
        .MAX_WORD  (MAX_WORD)
    ) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (w_load),
        .step    (w_step),
        .addr    (addr),
        .idx     (buf_addr),
        .in_cfg  (in_cfg),
        .at_ck   (at_ck),
        .at_last (at_last)
    );

    cfgs_poll #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (nv_cmd_wr),
        .waiting  (state == S_WAIT),
        .tick     (tick_1ms),
        .dev_done (nv_done),
        .ok       (poll_ok),
        .expire   (poll_exp)
    );

    cfgs_sum #(.W(WORD_W)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .acc   (sum_acc),
        .word  (sum_word),
        .sum   (sum)
    );

    assign busy      = state != S_IDLE;
    assign done      = state == S_FIN;
    assign timeout   = tmo_q;
    assign checksum  = sum;
    assign accept    = (state == S_IDLE) && start;
    assign buf_wdata = nv_rdata;
    assign sum_word  = (state == S_LOAD_DATA) ? buf_rdata : nv_rdata;
    assign w_load    = accept;

    // next-state, strobes and command formation
    always_comb begin
        state_n    = state;
        phase_n    = phase;
        nv_cmd_wr  = 1'b0;
        nv_cmd     = '0;
        nv_data_wr = 1'b0;
        nv_wdata   = '0;
        buf_we     = 1'b0;
        sum_acc    = 1'b0;
        w_step     = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) state_n = wr_mode ? S_UNLOCK : S_CMD;
            end
            S_UNLOCK: begin
                nv_cmd_wr = 1'b1;
                nv_cmd    = OP_UNLOCK;
                phase_n   = PH_UNLOCK;
                state_n   = S_WAIT;
            end
            S_LOAD_DATA: begin
                nv_data_wr = 1'b1;
                nv_wdata   = at_ck ? sum : buf_rdata;
                sum_acc    = in_cfg;
                state_n    = S_CMD;
            end
            S_CMD: begin
                nv_cmd_wr = 1'b1;
                nv_cmd    = (store_q ? OP_STORE : OP_LOAD) | WORD_W'(addr);
                phase_n   = PH_WORD;
                state_n   = S_WAIT;
            end
            S_WAIT: begin
                if (poll_exp) begin
                    state_n = S_FIN;
                end else if (poll_ok) begin
                    unique case (phase)
                        PH_UNLOCK: state_n = S_LOAD_DATA;
                        PH_LOCK:   state_n = S_FIN;
                        default: begin
                            buf_we  = !store_q;
                            sum_acc = !store_q && in_cfg;
                            if (at_last) begin
                                state_n = store_q ? S_LOCK : S_FIN;
                            end else begin
                                w_step  = 1'b1;
                                state_n = store_q ? S_LOAD_DATA : S_CMD;
                            end
                        end
                    endcase
                end
            end
            S_LOCK: begin
                nv_cmd_wr = 1'b1;
                nv_cmd    = OP_LOCK;
                phase_n   = PH_LOCK;
                state_n   = S_WAIT;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // state, wait phase, pass direction and timeout flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            phase   <= PH_WORD;
            store_q <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            state <= state_n;
            phase <= phase_n;
            if (accept) begin
                store_q <= wr_mode;
                tmo_q   <= 1'b0;
            end else if (state == S_WAIT && poll_exp) begin
                tmo_q <= 1'b1;
            end
        end
    end

    // R6: a data load is always followed at once by a store command
    a_r6_data_then_store: assert property (@(posedge clk) disable iff (!rst_n)
        nv_data_wr |=> (nv_cmd_wr && nv_cmd[15:12] == OP_STORE[15:12]));

    // R10: done lasts one cycle and ends the pass
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: busy holds until done
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R3: the buffer is written only by load passes
    a_r3_buf_we_load_only: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !store_q);

    // R2: at most one register strobe per cycle
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nv_cmd_wr, nv_data_wr, buf_we}));
endmodule

// File: tb/tb_cfgs_seq.sv
module tb_cfgs_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1ms = 1'b0;
    logic        start = 1'b0;
    logic        wr_mode = 1'b0;
    logic        busy, done, timeout;
    logic [15:0] checksum;
    logic [5:0]  buf_addr;
    logic [15:0] buf_rdata;
    logic        buf_we;
    logic [15:0] buf_wdata;
    logic        nv_cmd_wr;
    logic [15:0] nv_cmd;
    logic        nv_data_wr;
    logic [15:0] nv_wdata;
    logic [15:0] nv_rdata;
    logic        nv_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    cfgs_seq dut (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .start(start),
        .wr_mode(wr_mode), .busy(busy), .done(done), .timeout(timeout),
        .checksum(checksum), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .nv_cmd_wr(nv_cmd_wr),
        .nv_cmd(nv_cmd), .nv_data_wr(nv_data_wr), .nv_wdata(nv_wdata),
        .nv_rdata(nv_rdata), .nv_done(nv_done)
    );

    always #2 clk = ~clk;

    // tick every 4 cycles
    logic [1:0] tdiv = 2'd0;
    always @(posedge clk) begin
        tdiv     <= tdiv + 2'd1;
        tick_1ms <= (tdiv == 2'd3);
    end

    // memory, buffer and device model (sole writer of its arrays)
    logic [15:0] mem  [64];
    logic [15:0] bufm [64];
    logic [15:0] clog [128];
    int          logn = 0;
    int          order_err = 0;
    int          pend = 0;
    logic        prev_data = 1'b0;
    logic        unlocked = 1'b0;
    logic [15:0] dreg = '0;
    logic [15:0] lastcmd = '0;
    logic        dead = 1'b0;
    logic        fill_mem = 1'b0, fill_buf = 1'b0, clr_log = 1'b0;
    int          fill_seed = 0;
    logic        nv_done_r = 1'b0;
    logic [15:0] nv_rdata_r = '0;

    assign nv_done   = nv_done_r;
    assign nv_rdata  = nv_rdata_r;
    assign buf_rdata = bufm[buf_addr];

    function automatic logic [15:0] pat(int s, int i);
        if (s == 0) return 16'hFFFF;
        return 16'(s * 40503 + i * 977 + (i << 9));
    endfunction

    always @(posedge clk) begin
        if (fill_mem) for (int i = 0; i < 64; i++) mem[i] <= pat(fill_seed, i);
        if (fill_buf) for (int i = 0; i < 64; i++) bufm[i] <= pat(fill_seed, i);
        if (buf_we) bufm[buf_addr] <= buf_wdata;
        prev_data <= nv_data_wr;
        if (nv_data_wr) dreg <= nv_wdata;
        if (clr_log) logn <= 0;
        if (nv_cmd_wr) begin
            if (logn < 128) clog[logn] <= nv_cmd;
            logn <= logn + 1;
            if (nv_cmd[15:12] == 4'h4 && !prev_data) order_err <= order_err + 1;
            pend      <= 2;
            nv_done_r <= 1'b0;
            lastcmd   <= nv_cmd;
        end else if (pend > 0) begin
            pend <= pend - 1;
            if (pend == 1 && !dead) begin
                nv_done_r <= 1'b1;
                case (lastcmd[15:12])
                    4'h8: nv_rdata_r <= mem[lastcmd[5:0]];
                    4'h4: if (unlocked) mem[lastcmd[5:0]] <= dreg;
                    4'h3: unlocked <= 1'b1;
                    4'h1: unlocked <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // ticks seen between a command strobe and the end of the pass
    int  tcount = 0;
    logic twait = 1'b0;
    always @(posedge clk) begin
        if (nv_cmd_wr) begin
            twait  <= 1'b1;
            tcount <= 0;
        end else if (done) begin
            twait <= 1'b0;
        end else if (twait && tick_1ms) begin
            tcount <= tcount + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                finish_run();
            end
        end
    end

    task automatic fill(bit to_mem, int seed);
        @(negedge clk);
        fill_seed = seed;
        if (to_mem) fill_mem = 1'b1; else fill_buf = 1'b1;
        @(negedge clk);
        fill_mem = 1'b0;
        fill_buf = 1'b0;
    endtask

    // start a pass, check busy one cycle later, wait for done
    task automatic run_pass(bit store);
        @(negedge clk);
        clr_log = 1'b1;
        @(negedge clk);
        clr_log = 1'b0;
        start   = 1'b1;
        wr_mode = store;
        @(negedge clk);
        start   = 1'b0;
        wr_mode = 1'b0;
        check("R9 busy after start", busy, 1);
        check("R10 timeout cleared by start", timeout, 0);
        while (!done) @(negedge clk);
        @(negedge clk);
        check("R10 done single cycle", {done, busy}, 2'b00);
    endtask

    function automatic logic [15:0] cfg_sum(int seed);
        logic [15:0] s = '0;
        for (int i = 0; i < 21; i++) s += pat(seed, i);
        return s;
    endfunction

    task automatic t_reset();
        check("R1 reset busy/done/timeout", {busy, done, timeout}, 3'b000);
        check("R1 reset strobes", {nv_cmd_wr, nv_data_wr, buf_we}, 3'b000);
        check("R1 reset checksum", checksum, 16'h0000);
    endtask

    task automatic t_load(int seed);
        int bad = 0, cbad = 0;
        fill(1'b1, seed);
        run_pass(1'b0);
        check("R4 load checksum", checksum, cfg_sum(seed));
        check("R8 no timeout", timeout, 0);
        check("R3 load command count", logn, 64);
        for (int i = 0; i < 64; i++) begin
            if (clog[i] !== (16'h8000 | 16'(i))) cbad++;
            if (bufm[i] !== pat(seed, i)) bad++;
        end
        check("R2 R3 load command words", cbad, 0);
        check("R3 buffer contents", bad, 0);
    endtask

    task automatic t_store(int seed);
        int bad = 0, cbad = 0;
        logic [15:0] s;
        fill(1'b0, seed);
        fill(1'b1, seed + 99);
        s = cfg_sum(seed);
        run_pass(1'b1);
        check("R5 store command count", logn, 66);
        check("R5 unlock first", clog[0], 16'h3000);
        check("R5 lock last", clog[65], 16'h1000);
        for (int i = 0; i < 64; i++)
            if (clog[i + 1] !== (16'h4000 | 16'(i))) cbad++;
        check("R2 store command words", cbad, 0);
        check("R6 data load before each store", order_err, 0);
        check("R7 checksum word written", mem[21], s);
        for (int i = 0; i < 64; i++)
            if (i != 21 && mem[i] !== pat(seed, i)) bad++;
        check("R7 other words from buffer", bad, 0);
        check("R4 store reports sum", checksum, s);
    endtask

    task automatic t_timeout();
        @(negedge clk);
        dead = 1'b1;
        run_pass(1'b0);
        check("R8 timeout set", timeout, 1);
        check("R8 single command then stop", logn, 1);
        check("R8 ticks before expiry", tcount, 10);
        repeat (6) @(negedge clk);
        check("R10 timeout sticky", {timeout, busy, nv_cmd_wr}, 3'b100);
        dead = 1'b0;
        t_load(5);
        check("R10 timeout cleared after good pass", timeout, 0);
    endtask

    task automatic t_busy_ignore();
        fill(1'b1, 11);
        @(negedge clk);
        clr_log = 1'b1;
        @(negedge clk);
        clr_log = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        start   = 1'b1;
        wr_mode = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        wr_mode = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check("R9 second start ignored (count)", logn, 64);
        check("R9 second start ignored (no unlock)", clog[0], 16'h8000);
        check("R9 pass result intact", checksum, cfg_sum(11));
        check("R9 idle after pass", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_load(3);
        t_load(0);
        t_store(7);
        t_timeout();
        t_busy_ignore();
        finish_run();
    end
endmodule